// File: doc/BRIEF.md
# Compact Instruction Expander

This block turns a stream of 16-bit compact instruction words into the equivalent 32-bit standard instruction words. Each accepted input word is either a prefix or an instruction. A prefix is absorbed and produces nothing. Its low eleven bits are held so that they can widen the immediate field of the instruction that follows it. The block recognises nop, register move, doubleword load, doubleword store and add-immediate to the stack pointer. Every other encoding becomes one fixed illegal word.

The input and the output are valid/ready streams. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no input is taken. Prefix words obey the same rule. An accepted instruction appears on the output on the next clock edge.

The 32-bit result is laid out as follows: bits [31:26] hold the opcode, [25:21] the source register, [20:16] the target register and [15:0] the immediate. Compact 3-bit register codes 0..7 name the full registers 16, 17, 2, 3, 4, 5, 6 and 7.

Top module: `cx_expander`

## Requirements
- R1: An accepted word with bits [15:11] = 11110 is a prefix. It produces no output word, and its bits [10:0] are held as the pending prefix.
- R2: The word 0x6500 expands to 0x00000000.
- R3: A compact register code c (0..7) maps to full register 16+c when c < 2, and to c otherwise.
- R4: A word with upper byte 0x67 expands to opcode 0x09, source x[4:0], target map(x[7:5]) and immediate 0.
- R5: A word with x[15:11] = 00111 expands to opcode 0x37, source map(x[10:8]) and target map(x[7:5]). With no prefix pending, the immediate is x[4:0]·8, zero-extended.
- R6: A word with upper byte 0xF9 expands like R5, with opcode 0x3F.
- R7: With a prefix p pending, the R5/R6 immediate is x[4:0]·2048 + p[10:0].
- R8: A word with upper byte 0xFB expands to opcode 0x19 with source and target both 29. With no prefix pending, the immediate is x[7:0]·8 sign-extended from bit 10. With prefix p pending, it is (p[10:0]·32 + x[7:0]) mod 65536.
- R9: Any other non-prefix word expands to 0xF8000000.
- R10: The first accepted non-prefix word clears the pending prefix, whatever that word is. A second prefix replaces the first.
- R11: Each accepted non-prefix word yields exactly one output on the next edge, in input order. While `out_valid && !out_ready`, `out_valid` stays high and `out_word` stays stable, and `in_ready` is low.
- R12: Synchronous reset empties the output (`out_valid` = 0, `in_ready` = 1) and clears the pending prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept an input word |
| in_word | input | 16 | Compact instruction or prefix word |
| out_valid | output | 1 | Expanded word present |
| out_ready | input | 1 | Consumer takes the expanded word |
| out_word | output | 32 | Expanded 32-bit instruction |

## Verification
The bench builds the block with its default 16-bit input and 32-bit output widths. At that size every one of the 65536 input words can be driven in one sweep, so each encoding class, each register code and each immediate value is reached, including the chains of prefixes that replace one another. A second sweep places several prefix values, among them all-ones and all-zeros, ahead of every load, store and stack-add word to reach the widened immediates. A third phase throttles `out_ready` to exercise holding the output under back-pressure and clearing the prefix across stalls.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int HALF_W = 16;
  localparam int FULL_W = 32;
  localparam int REG_W  = 5;
  localparam int CODE_W = 3;
  localparam int OPC_W  = 6;
  localparam int IMM_W  = 16;
  localparam int PFX_W  = 11;

  localparam logic [OPC_W-1:0] OPC_ADDIU  = 6'h09;
  localparam logic [OPC_W-1:0] OPC_LOADD  = 6'h37;
  localparam logic [OPC_W-1:0] OPC_STORED = 6'h3F;
  localparam logic [OPC_W-1:0] OPC_DADDIU = 6'h19;
  localparam logic [OPC_W-1:0] OPC_BAD    = 6'h3E;
  localparam logic [REG_W-1:0] REG_SP     = 5'd29;

  typedef enum logic [2:0] {
    K_PREFIX,
    K_NOP,
    K_MOVE,
    K_LOAD,
    K_STORE,
    K_SPADD,
    K_BAD
  } kind_e;
endpackage

// File: rtl/cx_regmap.sv
module cx_regmap #(
  parameter int CW = 3,
  parameter int RW = 5,
  parameter int LOW_BASE = 16,
  parameter int LOW_CNT = 2
) (
  input  logic [CW-1:0] code,
  output logic [RW-1:0] full
);
  localparam int ENTRIES = 1 << CW;
  logic [RW-1:0] lut [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam int VAL = (i < LOW_CNT) ? (LOW_BASE + i) : i;
    assign lut[i] = RW'(VAL);
  end

  assign full = lut[code];
endmodule

// File: rtl/cx_classify.sv
module cx_classify
  import cx_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic [HW-1:0] word,
  output kind_e         kind
);
  always_comb begin
    if (word[HW-1 -: 5] == 5'b11110)       kind = K_PREFIX;
    else if (word == HW'(16'h6500))         kind = K_NOP;
    else if (word[HW-1 -: 8] == 8'h67)      kind = K_MOVE;
    else if (word[HW-1 -: 5] == 5'b00111)  kind = K_LOAD;
    else if (word[HW-1 -: 8] == 8'hF9)      kind = K_STORE;
    else if (word[HW-1 -: 8] == 8'hFB)      kind = K_SPADD;
    else                                    kind = K_BAD;
  end
endmodule

// File: rtl/cx_build.sv
module cx_build
  import cx_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int FW = FULL_W,
  parameter int PW = PFX_W
) (
  input  logic [HW-1:0] word,
  input  kind_e         kind,
  input  logic          pend,
  input  logic [PW-1:0] pfx,
  output logic [FW-1:0] expanded
);
  logic [REG_W-1:0] tgt_reg, base_reg;
  logic [IMM_W-1:0] mem_imm, sp_imm;

  cx_regmap #(.CW(CODE_W), .RW(REG_W)) u_map_tgt (
    .code (word[7:5]),
    .full (tgt_reg)
  );
  cx_regmap #(.CW(CODE_W), .RW(REG_W)) u_map_base (
    .code (word[10:8]),
    .full (base_reg)
  );

  always_comb begin
    if (pend) mem_imm = {word[4:0], pfx};
    else      mem_imm = {8'b0, word[4:0], 3'b000};
  end

  always_comb begin
    if (pend) sp_imm = {pfx, 5'b0} + {8'b0, word[7:0]};
    else      sp_imm = {{5{word[7]}}, word[7:0], 3'b000};
  end

  always_comb begin
    case (kind)
      K_NOP:   expanded = '0;
      K_MOVE:  expanded = {OPC_ADDIU, word[4:0], tgt_reg, 16'h0000};
      K_LOAD:  expanded = {OPC_LOADD, base_reg, tgt_reg, mem_imm};
      K_STORE: expanded = {OPC_STORED, base_reg, tgt_reg, mem_imm};
      K_SPADD: expanded = {OPC_DADDIU, REG_SP, REG_SP, sp_imm};
      default: expanded = {OPC_BAD, {(FW-OPC_W){1'b0}}};
    endcase
  end
endmodule

// File: rtl/cx_prefix.sv
module cx_prefix #(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          is_pfx,
  input  logic [PW-1:0] bits,
  output logic          pend,
  output logic [PW-1:0] pfx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      pfx  <= '0;
    end else if (take) begin
      pend <= is_pfx;
      if (is_pfx) pfx <= bits;
    end
  end

  assert_pfx_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (take && !is_pfx) |=> !pend);

  assert_pfx_keep_R1: assert property (@(posedge clk) disable iff (rst)
    (take && is_pfx) |=> (pend && pfx == $past(bits)));

  assert_reset_clear_R12: assert property (@(posedge clk)
    $past(rst) |-> !pend);
endmodule

// File: rtl/cx_outreg.sv
module cx_outreg #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [FW-1:0] out_word,
  output logic          can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  assert_issue_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> (out_valid && out_word == $past(din)));

  assert_reset_idle_R12: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int FW = FULL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [HW-1:0] in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [FW-1:0] out_word
);
  kind_e            kind;
  logic             take, is_pfx, pend;
  logic [PFX_W-1:0] pfx;
  logic [FW-1:0]    expanded;

  cx_classify #(.HW(HW)) u_cls (
    .word (in_word),
    .kind (kind)
  );

  assign is_pfx = (kind == K_PREFIX);
  assign take   = in_valid && in_ready;

  cx_prefix #(.PW(PFX_W)) u_pfx (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .is_pfx (is_pfx),
    .bits   (in_word[PFX_W-1:0]),
    .pend   (pend),
    .pfx    (pfx)
  );

  cx_build #(.HW(HW), .FW(FW), .PW(PFX_W)) u_bld (
    .word     (in_word),
    .kind     (kind),
    .pend     (pend),
    .pfx      (pfx),
    .expanded (expanded)
  );

  cx_outreg #(.FW(FW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (take && !is_pfx),
    .din       (expanded),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .can_take  (in_ready)
  );

  assert_prefix_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (take && is_pfx) |=> !out_valid);

  assert_stall_block_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/cx_expander_tb.sv
`timescale 1ns/1ps
module cx_expander_tb;
  logic        clk = 0, rst = 1;
  logic        in_valid = 0, out_ready = 1;
  logic [15:0] in_word = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_word;

  int total = 0, bad = 0;
  logic [31:0] expq[$];
  string       reqq[$];
  bit          m_pend = 0;
  logic [10:0] m_pfx = '0;
  bit          bp_mode = 0;
  int          bp_cnt = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_word = '0;
  bit          done = 0;

  cx_expander u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // R3 map computed arithmetically
  function automatic int rmap(input int c);
    return (c < 2) ? c + 16 : c;
  endfunction

  function automatic string req_of(input logic [15:0] x, input bit pend);
    if (x == 16'h6500) return "R2";
    if (x[15:8] == 8'h67) return "R4/R3";
    if (x[15:11] == 5'b00111) return pend ? "R7" : "R5/R3";
    if (x[15:8] == 8'hF9) return pend ? "R7" : "R6";
    if (x[15:8] == 8'hFB) return "R8";
    return "R9";
  endfunction

  function automatic logic [31:0] model(input logic [15:0] x, input bit pend,
                                        input logic [10:0] p);
    int imm;
    if (x == 16'h6500) return 32'h0;
    if (x[15:8] == 8'h67)
      return (32'h09 << 26) + (int'(x[4:0]) << 21) + (rmap(int'(x[7:5])) << 16);
    if (x[15:11] == 5'b00111 || x[15:8] == 8'hF9) begin
      imm = pend ? int'(x[4:0]) * 2048 + int'(p) : int'(x[4:0]) * 8;
      return ((x[15:8] == 8'hF9 ? 32'h3F : 32'h37) << 26) +
             (rmap(int'(x[10:8])) << 21) + (rmap(int'(x[7:5])) << 16) + imm;
    end
    if (x[15:8] == 8'hFB) begin
      if (pend) imm = (int'(p) * 32 + int'(x[7:0])) % 65536;
      else begin
        imm = int'(x[7:0]) * 8;
        if (imm >= 1024) imm = imm + 16'hF800;
      end
      return (32'h19 << 26) + (29 << 21) + (29 << 16) + imm;
    end
    return 32'hF800_0000;
  endfunction

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1;
    in_word  = w;
    forever begin
      out_ready = bp_mode ? (bp_cnt % 3 != 0) : 1'b1;
      bp_cnt++;
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    if (w[15:11] == 5'b11110) begin
      m_pend = 1;
      m_pfx  = w[10:0];
    end else begin
      expq.push_back(model(w, m_pend, m_pfx));
      reqq.push_back(req_of(w, m_pend));
      m_pend = 0;
    end
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 0;
    while (expq.size() != 0 || out_valid) begin
      out_ready = 1;
      @(negedge clk);
    end
  endtask

  // monitor: pre-update values at the rising edge
  always @(posedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(out_valid && out_word == prev_word, "R11 hold", out_word, prev_word);
      if (out_valid && out_ready) begin
        if (expq.size() == 0)
          check(0, "R1 unexpected output", out_word, 32'hx);
        else
          check(out_word === expq[0], reqq[0], out_word, expq[0]);
        if (expq.size() != 0) begin
          void'(expq.pop_front());
          void'(reqq.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_word  = out_word;
    end else prev_stall = 0;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      check(0, "watchdog", 0, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pfxs[4] = '{16'hF000, 16'hF7FF, 16'hF555, 16'hF2AA};
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R12 reset state
    check(out_valid == 0, "R12 out_valid", 32'(out_valid), 0);
    check(in_ready == 1, "R12 in_ready", 32'(in_ready), 1);

    // R10: prefix then nop, then load must be unprefixed
    send(16'hF7FF);
    @(negedge clk); in_valid = 0; #1;
    check(out_valid == 0, "R1 prefix silent", 32'(out_valid), 0);
    send(16'h6500);
    send(16'h3BFF);   // R10 expects x*8 immediate
    send(16'hF123);   // R10 replace
    send(16'hF456);
    send(16'hF93F);
    drain();

    // R12: prefix cleared by reset
    send(16'hF7FF);
    @(negedge clk); in_valid = 0; rst = 1;
    @(negedge clk); rst = 0; m_pend = 0;
    send(16'hFB80);   // R12 expects unprefixed stack add
    drain();

    // full sweep of the 16-bit input space
    for (int i = 0; i < 65536; i++) send(16'(i));
    drain();

    // R7/R8: each prefix before every load, store and stack-add word
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 2048; j++) begin send(pfxs[k]); send(16'h3800 | 16'(j)); end
      for (int j = 0; j < 256; j++) begin send(pfxs[k]); send(16'hF900 | 16'(j)); end
      for (int j = 0; j < 256; j++) begin send(pfxs[k]); send(16'hFB00 | 16'(j)); end
    end
    drain();

    // R11: back-pressure with mixed words
    bp_mode = 1;
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 5 == 0) send({5'b11110, lf[10:0]});
      else if (i % 5 == 1) send({5'b00111, lf[10:0]});
      else if (i % 5 == 2) send({8'hFB, lf[7:0]});
      else send(lf);
    end
    bp_mode = 0;
    drain();
    check(expq.size() == 0, "R11 all outputs delivered", 32'(expq.size()), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule